// File: doc/BRIEF.md
# Timed Self-Programming Command Controller

This block is the control and status unit that sits beside a small processor's flash self-programming path. Software writes a command pattern into an 8-bit control register. A correct pattern opens a short window that counts down on its own. A store-program strobe that arrives inside that window programs lock bits. A load-program strobe that arrives inside the window returns the lock bits or the low fuse byte, chosen by a 16-bit pointer. If no strobe arrives before the window runs out, the command bits clear silently.

The unit also provides three further functions. It blocks command writes and lock or fuse access while an EEPROM write is in progress. It counts a fixed busy period after each lock-programming operation. It keeps a read-while-write busy flag that is set by page erase or page write and that only a software acknowledge clears. Outside an accepted read, load-program strobes return ordinary program-memory data, which is passed through from an input.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset the lock bits read 6'h3F (all unprogrammed), the control readback `reg_rdata` is 8'h00, `prog_busy` is 0 and the read-while-write flag (readback bit 6) is 0.
- R2: A control write arms a command only if bit 0 is 1 and bits 6..1 equal 6'b000100 (bit 3 set). Bit 7 is don't-care. While armed, readback bits 3 and 0 read 1 (8'h09). Any other pattern leaves them 0.
- R3: A store-program strobe is accepted only at the 1st to 4th clock edge after the arming edge. A strobe at the 5th edge or later changes no lock bit and starts no busy period.
- R4: A load-program strobe is a command read only at the 1st to 3rd edge after the arming edge. At the 4th edge it returns `flash_rdata`.
- R5: Readback bits 3 and 0 return to 0 after an accepted strobe, or on their own after 4 edges with no accepted strobe.
- R6: An accepted store-program strobe programs (clears) each lock bit whose `data_in` bit among 5..0 is 0. A programmed lock bit never returns to 1. `zptr` has no effect on this operation.
- R7: `lpm_rdata` updates at the edge that samples a load-program strobe. For an accepted read, pointer 16'h0001 gives {2'b11, lock bits} with bit 5 BLB12 down to bit 0 LB1, and pointer 16'h0000 gives the low fuse byte (default 8'hFF). Any other pointer, or any strobe outside a read window, gives `flash_rdata`.
- R8: While `ee_busy` is 1, control writes are ignored, no lock bit changes, and armed load strobes return `flash_rdata`.
- R9: `prog_busy` is 1 for exactly 8 cycles after an accepted lock write. Arming writes made while it is 1 are ignored.
- R10: The read-while-write flag (readback bit 6) is set while `page_busy` is 1. It stays set after `page_busy` falls. It is cleared only by an accepted control write with bit 4 set while `page_busy` is 0.
- R11: During `prog_busy`, a load-program strobe outside a window returns `flash_rdata` (the flash array stays readable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| spm_strobe | input | 1 | Store-program instruction strobe |
| lpm_strobe | input | 1 | Load-program instruction strobe |
| zptr | input | 16 | Pointer operand |
| data_in | input | 8 | Data operand for lock writes |
| flash_rdata | input | 8 | Normal program-memory read data |
| lpm_rdata | output | 8 | Load-program result |
| ee_busy | input | 1 | EEPROM write in progress |
| page_busy | input | 1 | Page erase or page write in progress |
| prog_busy | output | 1 | Lock-bit programming busy |
| lock_bits | output | 6 | Current lock bits, 1 = unprogrammed |

## Verification
Two functions can fall in the same cycle. The first is the window's auto-clear, and the second is a strobe arriving on the window's final edge: the 4th edge for store, the 3rd for load. Directed tasks place the strobe exactly on that last edge and then one edge later. The first case must update lock or read data and the second must leave them unchanged. The EEPROM-busy block is provoked in the same way, by raising `ee_busy` while a window is already open. The bench then judges that neither the lock bits nor the read result take the command path.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;
   localparam int LOCK_W     = 6;
   localparam int DATA_W     = 8;
   localparam int B_EN       = 0;
   localparam int B_LOCKSET  = 3;
   localparam int B_RDEN     = 4;
   localparam int B_RWWBUSY  = 6;
   localparam logic [5:0] ARM_MID = 6'b000100;
   localparam logic [15:0] PTR_LOCK = 16'h0001;
   localparam logic [15:0] PTR_FUSE = 16'h0000;
endpackage

// File: rtl/selfprog_window.sv
module selfprog_window #(
   parameter int SPM_WIN = 4,
   parameter int LPM_WIN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic done,
   output logic spm_ok,
   output logic lpm_ok,
   output logic armed
);
   localparam int CW = $clog2(SPM_WIN + 1);
   localparam logic [CW-1:0] START   = CW'(SPM_WIN);
   localparam logic [CW-1:0] LPM_MIN = CW'(SPM_WIN - LPM_WIN + 1);

   generate
      if (LPM_WIN < 1 || LPM_WIN > SPM_WIN) begin : g_bad_win
         $error("selfprog_window: LPM_WIN must be within 1..SPM_WIN");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (arm)
         cnt_q <= START;
      else if (done)
         cnt_q <= '0;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign armed  = (cnt_q != '0);
   assign spm_ok = armed;
   assign lpm_ok = (cnt_q >= LPM_MIN);
endmodule

// File: rtl/selfprog_lockbank.sv
module selfprog_lockbank #(
   parameter int LOCK_W   = 6,
   parameter int PROG_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [LOCK_W-1:0] wr_data,
   output logic [LOCK_W-1:0] lock_q,
   output logic              busy
);
   localparam int BW = $clog2(PROG_CYC + 1);
   localparam logic [BW-1:0] BUSY_START = BW'(PROG_CYC);

   generate
      if (PROG_CYC < 1) begin : g_bad_cyc
         $error("selfprog_lockbank: PROG_CYC must be at least 1");
      end
      for (genvar i = 0; i < LOCK_W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lock_q[i] <= 1'b1;
            else if (wr_en && !wr_data[i])
               lock_q[i] <= 1'b0;
         end
      end
   endgenerate

   logic [BW-1:0] bcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bcnt_q <= '0;
      else if (wr_en)
         bcnt_q <= BUSY_START;
      else if (bcnt_q != '0)
         bcnt_q <= bcnt_q - 1'b1;
   end

   assign busy = (bcnt_q != '0);
endmodule

// File: rtl/selfprog_rww.sv
module selfprog_rww (
   input  logic clk,
   input  logic rst_n,
   input  logic page_busy,
   input  logic clr_req,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (page_busy)
         flag <= 1'b1;
      else if (clr_req)
         flag <= 1'b0;
   end
endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
   import selfprog_pkg::*;
#(
   parameter int          SPM_WIN      = 4,
   parameter int          LPM_WIN      = 3,
   parameter int          PROG_CYC     = 8,
   parameter logic [7:0]  FUSE_LOW_VAL = 8'hFF,
   parameter bit          LPM_REG      = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic        spm_strobe,
   input  logic        lpm_strobe,
   input  logic [15:0] zptr,
   input  logic [7:0]  data_in,
   input  logic [7:0]  flash_rdata,
   output logic [7:0]  lpm_rdata,
   input  logic        ee_busy,
   input  logic        page_busy,
   output logic        prog_busy,
   output logic [5:0]  lock_bits
);
   logic wr_ok, arm_pat, arm, spm_hit, lpm_hit, done;
   logic spm_ok, lpm_ok, armed, rww_flag, rww_clr;
   logic [7:0] rd_sel;
   logic unused_bits;

   assign unused_bits = ^{reg_wdata[7], data_in[7:6]};

   assign wr_ok   = reg_wr && !ee_busy;
   assign arm_pat = reg_wdata[B_EN] && (reg_wdata[6:1] == ARM_MID);
   assign arm     = wr_ok && arm_pat && !prog_busy;
   assign spm_hit = spm_strobe && spm_ok && !ee_busy;
   assign lpm_hit = lpm_strobe && lpm_ok && !ee_busy;
   assign done    = spm_hit || lpm_hit;
   assign rww_clr = wr_ok && reg_wdata[B_RDEN];

   selfprog_window #(.SPM_WIN(SPM_WIN), .LPM_WIN(LPM_WIN)) i_window (
      .clk(clk), .rst_n(rst_n), .arm(arm), .done(done),
      .spm_ok(spm_ok), .lpm_ok(lpm_ok), .armed(armed)
   );

   selfprog_lockbank #(.LOCK_W(LOCK_W), .PROG_CYC(PROG_CYC)) i_lockbank (
      .clk(clk), .rst_n(rst_n), .wr_en(spm_hit), .wr_data(data_in[LOCK_W-1:0]),
      .lock_q(lock_bits), .busy(prog_busy)
   );

   selfprog_rww i_rww (
      .clk(clk), .rst_n(rst_n), .page_busy(page_busy),
      .clr_req(rww_clr), .flag(rww_flag)
   );

   always_comb begin
      rd_sel = flash_rdata;
      if (lpm_hit) begin
         if (zptr == PTR_LOCK)
            rd_sel = {2'b11, lock_bits};
         else if (zptr == PTR_FUSE)
            rd_sel = FUSE_LOW_VAL;
      end
   end

   generate
      if (LPM_REG) begin : g_lpm_reg
         logic [7:0] lpm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lpm_q <= '0;
            else if (lpm_strobe)
               lpm_q <= rd_sel;
         end
         assign lpm_rdata = lpm_q;
      end else begin : g_lpm_comb
         assign lpm_rdata = rd_sel;
      end
   endgenerate

   always_comb begin
      reg_rdata            = '0;
      reg_rdata[B_EN]      = armed;
      reg_rdata[B_LOCKSET] = armed;
      reg_rdata[B_RWWBUSY] = rww_flag;
   end
endmodule

// File: rtl/selfprog_ctrl_chk.sv
module selfprog_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic [7:0] reg_rdata,
   input logic       spm_strobe,
   input logic       ee_busy,
   input logic       page_busy,
   input logic       prog_busy,
   input logic [5:0] lock_bits
);
   assert_lock_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lock_bits & ~$past(lock_bits)) == 6'h00));

   assert_lock_needs_spm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(spm_strobe && reg_rdata[0]) |=> $stable(lock_bits));

   assert_ee_blocks_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_busy && !reg_rdata[0]) |=> !reg_rdata[0]);

   assert_busy_blocks_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_busy && !reg_rdata[0]) |=> !reg_rdata[0]);

   assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_busy) |-> $past(spm_strobe));

   assert_autoclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[0] && spm_strobe && !ee_busy && !reg_wr) |=> !reg_rdata[0]);

   assert_rww_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      page_busy |=> reg_rdata[6]);
endmodule

bind selfprog_ctrl selfprog_ctrl_chk i_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
   .spm_strobe(spm_strobe), .ee_busy(ee_busy), .page_busy(page_busy),
   .prog_busy(prog_busy), .lock_bits(lock_bits)
);

// File: tb/test_selfprog_ctrl.sv
module test_selfprog_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        spm_strobe = 1'b0;
   logic        lpm_strobe = 1'b0;
   logic [15:0] zptr = '0;
   logic [7:0]  data_in = 8'hFF;
   logic [7:0]  flash_rdata = 8'hA5;
   logic [7:0]  lpm_rdata;
   logic        ee_busy = 1'b0;
   logic        page_busy = 1'b0;
   logic        prog_busy;
   logic [5:0]  lock_bits;

   int checks = 0;
   int fails  = 0;
   logic [5:0] exp_lock = 6'h3F;

   always #2 clk = ~clk;

   selfprog_ctrl i_selfprog_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .spm_strobe(spm_strobe), .lpm_strobe(lpm_strobe),
      .zptr(zptr), .data_in(data_in), .flash_rdata(flash_rdata),
      .lpm_rdata(lpm_rdata), .ee_busy(ee_busy), .page_busy(page_busy),
      .prog_busy(prog_busy), .lock_bits(lock_bits)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic spm(input logic [7:0] d);
      spm_strobe = 1'b1; data_in = d;
      @(negedge clk);
      spm_strobe = 1'b0; data_in = 8'hFF;
   endtask

   task automatic lpm(input logic [15:0] p);
      lpm_strobe = 1'b1; zptr = p;
      @(negedge clk);
      lpm_strobe = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 readback in reset", reg_rdata, 8'h00);
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 readback", reg_rdata, 8'h00);
      chk("R1 lock", {2'b00, lock_bits}, 8'h3F);
      chk("R1 busy", {7'd0, prog_busy}, 8'h00);
   endtask

   task automatic t_arm_patterns;
      wr(8'h89); chk("R2 bit7 set arms", reg_rdata, 8'h09); cyc(5);
      wr(8'h09); chk("R2 plain arms", reg_rdata, 8'h09); cyc(5);
      wr(8'h0B); chk("R2 extra bit no arm", reg_rdata, 8'h00);
      wr(8'h08); chk("R2 no enable no arm", reg_rdata, 8'h00);
      cyc(2);
   endtask

   task automatic t_spm_window;
      wr(8'h09); cyc(3); spm(8'h3E);
      exp_lock = exp_lock & 6'h3E;
      chk("R3 spm at 4th edge", {2'b00, lock_bits}, {2'b00, exp_lock});
      cyc(10);
      wr(8'h09); cyc(4); spm(8'h3D);
      chk("R3 spm at 5th edge ignored", {2'b00, lock_bits}, {2'b00, exp_lock});
      chk("R3 no busy late spm", {7'd0, prog_busy}, 8'h00);
      cyc(2);
   endtask

   task automatic t_lpm_window;
      flash_rdata = 8'hA5;
      wr(8'h09); cyc(2); lpm(16'h0001);
      chk("R4 lpm at 3rd edge", lpm_rdata, {2'b11, exp_lock});
      cyc(5);
      wr(8'h09); cyc(3); lpm(16'h0001);
      chk("R4 lpm at 4th edge normal", lpm_rdata, 8'hA5);
      cyc(3);
   endtask

   task automatic t_autoclear;
      wr(8'h09); cyc(3);
      chk("R5 still armed", reg_rdata, 8'h09);
      cyc(1);
      chk("R5 timed out", reg_rdata, 8'h00);
      wr(8'h09); lpm(16'h0000);
      chk("R5 cleared after read", reg_rdata, 8'h00);
      cyc(2);
   endtask

   task automatic t_lock_write;
      zptr = 16'h1234;
      wr(8'h09); spm(8'hF5);
      exp_lock = exp_lock & 6'h35;
      chk("R6 program bits, ptr ignored", {2'b00, lock_bits}, {2'b00, exp_lock});
      cyc(10);
      wr(8'h09); spm(8'hFF);
      chk("R6 no unprogram", {2'b00, lock_bits}, {2'b00, exp_lock});
      cyc(10);
   endtask

   task automatic t_reads;
      flash_rdata = 8'h5A;
      wr(8'h09); lpm(16'h0000);
      chk("R7 fuse read", lpm_rdata, 8'hFF);
      wr(8'h09); lpm(16'h0001);
      chk("R7 lock read", lpm_rdata, {2'b11, exp_lock});
      wr(8'h09); lpm(16'h0005);
      chk("R7 other ptr", lpm_rdata, 8'h5A);
      lpm(16'h0001);
      chk("R7 no window", lpm_rdata, 8'h5A);
      cyc(5);
   endtask

   task automatic t_ee_block;
      ee_busy = 1'b1;
      wr(8'h09);
      chk("R8 write ignored", reg_rdata, 8'h00);
      ee_busy = 1'b0;
      flash_rdata = 8'h66;
      wr(8'h09);
      ee_busy = 1'b1;
      lpm(16'h0001);
      chk("R8 read blocked", lpm_rdata, 8'h66);
      spm(8'h00);
      chk("R8 lock write blocked", {2'b00, lock_bits}, {2'b00, exp_lock});
      ee_busy = 1'b0;
      cyc(5);
   endtask

   task automatic t_busy;
      wr(8'h09); spm(8'hFF);
      chk("R9 busy start", {7'd0, prog_busy}, 8'h01);
      wr(8'h09);
      chk("R9 arm ignored during busy", reg_rdata, 8'h00);
      cyc(6);
      chk("R9 busy 8th cycle", {7'd0, prog_busy}, 8'h01);
      cyc(1);
      chk("R9 busy ended", {7'd0, prog_busy}, 8'h00);
      cyc(2);
   endtask

   task automatic t_rww;
      page_busy = 1'b1; cyc(2);
      chk("R10 set", reg_rdata, 8'h40);
      wr(8'h10);
      chk("R10 no clear while page busy", reg_rdata, 8'h40);
      page_busy = 1'b0; cyc(3);
      chk("R10 sticky", reg_rdata, 8'h40);
      ee_busy = 1'b1; wr(8'h10); ee_busy = 1'b0;
      chk("R10 no clear during ee", reg_rdata, 8'h40);
      wr(8'h10);
      chk("R10 cleared", reg_rdata, 8'h00);
      cyc(2);
   endtask

   task automatic t_flash_busy;
      flash_rdata = 8'h3C;
      wr(8'h09); spm(8'hFF);
      cyc(1);
      lpm(16'h0001);
      chk("R11 busy still high", {7'd0, prog_busy}, 8'h01);
      chk("R11 flash read during busy", lpm_rdata, 8'h3C);
      cyc(10);
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_arm_patterns();
      t_spm_window();
      t_lpm_window();
      t_autoclear();
      t_lock_write();
      t_reads();
      t_ee_block();
      t_busy();
      t_rww();
      t_flash_busy();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule